// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block gives a host processor access to local packet memory through one data port. The host loads a 16-bit transfer pointer and a 16-bit remaining-byte count, picks byte or word width, and then reads or writes the data port. Each data-port access touches memory at the current pointer. The pointer then moves on by the access width and the count drops by the same amount. When the count runs out, a sticky completion flag is raised. The pointer follows the receive ring. When it lands on the ring's end address, it jumps back to the ring's first address.

A command write can ask for a remote read or a remote write while the count is already zero. In that case the completion flag is raised at once, so software that starts an empty transfer still sees it finish. Memory is reached through a 16-bit synchronous port with byte enables. Only two address windows hold real storage: a small identification area at the bottom of the space and the packet buffer. Accesses outside them never reach memory. Reads outside them return all ones.

The sequencer has two states. S_IDLE means no read data is pending. S_RDATA means read data is being presented. The transitions are: T_RD_ISSUE (S_IDLE to S_RDATA on a read strobe), T_RD_CHAIN (S_RDATA stays in S_RDATA on a back-to-back read strobe), T_RD_DONE (S_RDATA to S_IDLE with no read strobe) and T_IDLE_HOLD (S_IDLE stays in S_IDLE with no read strobe).

Top module: `rdma_port_engine`

## Requirements
- R1: After reset `dma_done` and `dp_rvalid` are low. The pointer, the count, the ring first and end pages, and the width select are all zero (byte mode).
- R2: Register selects on `reg_sel` are: 0 command, 1 ring first page, 2 ring end page, 3 width config, 4 pointer low byte, 5 pointer high byte, 6 count low byte, 7 count high byte, 8 status clear. A write to one half of the pointer or the count leaves the other half unchanged.
- R3: Bit 0 of the width config selects word mode, with a step of 2. When it is clear the block is in byte mode, with a step of 1. After each accepted access the pointer grows by the step, and a count larger than the step drops by the step.
- R4: The ring first address is the ring first page times 256, and the ring end address is the ring end page times 256. If the grown pointer equals the ring end address, it is replaced by the ring first address.
- R5: If the count at an accepted access is at most the step, the count becomes 0 and `dma_done` is set.
- R6: A data-port write while the count is 0 is ignored. It makes no memory access and leaves the pointer, the count and `dma_done` unchanged.
- R7: A command write with bit 0 (halt) clear, with bit 3 (remote read) or bit 4 (remote write) set, and with the count at 0 sets `dma_done` on the next edge. It does nothing when the halt bit is set or when the count is nonzero.
- R8: `dp_rvalid` is high, and `dp_rdata` is valid, exactly in the cycle after a `dp_rd` strobe. A byte read returns the addressed byte in bits 7:0 with bits 15:8 zero. `dp_rd` has priority over a simultaneous `dp_wr`.
- R9: Word accesses clear pointer bit 0 before addressing memory and enable both byte lanes. The byte at the even address is data bits 7:0 (little-endian). A byte access enables lane 0 for an even pointer and lane 1 for an odd pointer.
- R10: Valid addresses are below `PROM_BYTES` (32) or from `PMEM_LO` (0x4000) up to but not including `PMEM_HI` (0x8000). Outside them a read returns 0x00FF (byte) or 0xFFFF (word), a write makes no memory access, and the pointer and count still advance.
- R11: A status-clear write (select 8) with data bit 6 set clears `dma_done`. With bit 6 clear it has no effect. `dma_done` otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| dp_rd | input | 1 | Data port read strobe |
| dp_wr | input | 1 | Data port write strobe |
| dp_wdata | input | 16 | Data port write data |
| dp_rdata | output | 16 | Data port read data |
| dp_rvalid | output | 1 | Read data valid, cycle after `dp_rd` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory word address |
| mem_be | output | 2 | Memory byte lane enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after request |
| dma_done | output | 1 | Sticky remote-transfer-complete flag |

## Verification
Some rules are checked by properties on every cycle. These are: the count step and exhaustion, the ring wrap of the pointer, silence on the memory port for writes at zero count, memory requests only inside the two windows, full lane enables in word mode, one-cycle read latency, the immediate completion on an empty-transfer command, and the stickiness of the completion flag. The bench's scenarios are needed for the rest: returned data values and byte lane steering, the all-ones filler for stray reads, the preservation of the unwritten register half, and whether writes that were discarded or steered leave memory contents right. The bench shows these by reading the data back through the port later.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;
    localparam int PAGE_W = 8;

    localparam logic [3:0] SEL_CMD     = 4'd0;
    localparam logic [3:0] SEL_RFIRST  = 4'd1;
    localparam logic [3:0] SEL_REND    = 4'd2;
    localparam logic [3:0] SEL_WIDTH   = 4'd3;
    localparam logic [3:0] SEL_PTR_LO  = 4'd4;
    localparam logic [3:0] SEL_PTR_HI  = 4'd5;
    localparam logic [3:0] SEL_CNT_LO  = 4'd6;
    localparam logic [3:0] SEL_CNT_HI  = 4'd7;
    localparam logic [3:0] SEL_CLEAR   = 4'd8;

    localparam int CMD_HALT_BIT   = 0;
    localparam int CMD_RREAD_BIT  = 3;
    localparam int CMD_RWRITE_BIT = 4;
    localparam int WIDTH_WORD_BIT = 0;
    localparam int DONE_BIT       = 6;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_RDATA = 1'b1
    } rd_state_t;

    typedef struct packed {
        logic       lane_hi;
        logic       wide;
        logic       out_win;
    } rd_ctx_t;

endpackage

// File: rtl/rdma_regfile.sv
module rdma_regfile
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              adv,
    output logic [1:0]        step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic [ADDR_W-1:0] ring_start,
    output logic [ADDR_W-1:0] ring_stop,
    output logic              wide,
    output logic              dma_done
);

    logic [PAGE_W-1:0] first_pg, end_pg;
    logic [ADDR_W-1:0] addr_n, addr_sum;
    logic [CNT_W-1:0]  cnt_n;
    logic              set_done, clr_done;

    assign step       = wide ? 2'd2 : 2'd1;
    assign ring_start = {first_pg, {(ADDR_W-PAGE_W){1'b0}}};
    assign ring_stop  = {end_pg,   {(ADDR_W-PAGE_W){1'b0}}};
    assign addr_sum   = cur_addr + ADDR_W'(step);

    always_comb begin
        addr_n   = cur_addr;
        cnt_n    = cur_cnt;
        set_done = 1'b0;
        clr_done = 1'b0;
        if (adv) begin
            addr_n = (addr_sum == ring_stop) ? ring_start : addr_sum;
            if (cur_cnt <= CNT_W'(step)) begin
                cnt_n    = '0;
                set_done = 1'b1;
            end else begin
                cnt_n = cur_cnt - CNT_W'(step);
            end
        end
        if (reg_wr) begin
            unique case (reg_sel)
                SEL_PTR_LO: addr_n[7:0]  = reg_wdata;
                SEL_PTR_HI: addr_n[15:8] = reg_wdata;
                SEL_CNT_LO: cnt_n[7:0]   = reg_wdata;
                SEL_CNT_HI: cnt_n[15:8]  = reg_wdata;
                SEL_CMD: begin
                    if (!reg_wdata[CMD_HALT_BIT] &&
                        (reg_wdata[CMD_RREAD_BIT] || reg_wdata[CMD_RWRITE_BIT]) &&
                        (cur_cnt == '0))
                        set_done = 1'b1;
                end
                SEL_CLEAR: clr_done = reg_wdata[DONE_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            first_pg <= '0;
            end_pg   <= '0;
            wide     <= 1'b0;
            dma_done <= 1'b0;
        end else begin
            cur_addr <= addr_n;
            cur_cnt  <= cnt_n;
            if (set_done)
                dma_done <= 1'b1;
            else if (clr_done)
                dma_done <= 1'b0;
            if (reg_wr && reg_sel == SEL_RFIRST) first_pg <= reg_wdata;
            if (reg_wr && reg_sel == SEL_REND)   end_pg   <= reg_wdata;
            if (reg_wr && reg_sel == SEL_WIDTH)  wide     <= reg_wdata[WIDTH_WORD_BIT];
        end
    end

endmodule

// File: rtl/rdma_window.sv
module rdma_window
    import rdma_pkg::*;
#(
    parameter int PROM_BYTES = 32,
    parameter int PMEM_LO    = 16'h4000,
    parameter int PMEM_HI    = 16'h8000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              in_win,
    output logic [1:0]        lane_be
);

    logic in_prom, in_pmem;

    assign eff_addr = wide ? {addr[ADDR_W-1:1], 1'b0} : addr;
    assign in_pmem  = ({16'd0, eff_addr} >= 32'(PMEM_LO)) && ({16'd0, eff_addr} < 32'(PMEM_HI));

    generate
        if (PROM_BYTES > 0) begin : g_prom
            assign in_prom = {16'd0, eff_addr} < 32'(PROM_BYTES);
        end else begin : g_noprom
            assign in_prom = 1'b0;
        end
    endgenerate

    assign in_win  = in_prom || in_pmem;
    assign lane_be = wide ? 2'b11 : (eff_addr[0] ? 2'b10 : 2'b01);

endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
    import rdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dp_rd,
    input  logic              dp_wr,
    input  logic [15:0]       dp_wdata,
    input  logic              cnt_zero,
    input  logic              wide,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              in_win,
    input  logic [1:0]        lane_be,
    input  logic [15:0]       mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    output logic              adv,
    output logic [15:0]       dp_rdata,
    output logic              dp_rvalid
);

    rd_state_t state, state_n;
    rd_ctx_t   ctx;
    logic      rd_go, wr_go;

    assign rd_go = dp_rd;
    assign wr_go = dp_wr && !dp_rd && !cnt_zero;

    always_comb begin
        unique case (state)
            S_IDLE:  state_n = rd_go ? S_RDATA : S_IDLE;
            S_RDATA: state_n = rd_go ? S_RDATA : S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            ctx   <= '0;
        end else begin
            state <= state_n;
            if (rd_go) begin
                ctx.lane_hi <= eff_addr[0];
                ctx.wide    <= wide;
                ctx.out_win <= !in_win;
            end
        end
    end

    always_comb begin
        adv       = rd_go || wr_go;
        mem_req   = (rd_go || wr_go) && in_win;
        mem_we    = wr_go;
        mem_addr  = eff_addr[ADDR_W-1:1];
        mem_be    = lane_be;
        mem_wdata = wide ? dp_wdata : {dp_wdata[7:0], dp_wdata[7:0]};
        dp_rvalid = 1'b0;
        dp_rdata  = '0;
        unique case (state)
            S_IDLE: ;
            S_RDATA: begin
                dp_rvalid = 1'b1;
                if (ctx.out_win)
                    dp_rdata = ctx.wide ? 16'hFFFF : 16'h00FF;
                else if (ctx.wide)
                    dp_rdata = mem_rdata;
                else
                    dp_rdata = {8'h00, ctx.lane_hi ? mem_rdata[15:8] : mem_rdata[7:0]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter int PROM_BYTES = 32,
    parameter int PMEM_LO    = 16'h4000,
    parameter int PMEM_HI    = 16'h8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic        dp_rd,
    input  logic        dp_wr,
    input  logic [15:0] dp_wdata,
    output logic [15:0] dp_rdata,
    output logic        dp_rvalid,
    output logic        mem_req,
    output logic        mem_we,
    output logic [14:0] mem_addr,
    output logic [1:0]  mem_be,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        dma_done
);

    logic [1:0]        step;
    logic [ADDR_W-1:0] cur_addr, ring_start, ring_stop, eff_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic              wide, adv, in_win;
    logic [1:0]        lane_be;

    rdma_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .adv        (adv),
        .step       (step),
        .cur_addr   (cur_addr),
        .cur_cnt    (cur_cnt),
        .ring_start (ring_start),
        .ring_stop  (ring_stop),
        .wide       (wide),
        .dma_done   (dma_done)
    );

    rdma_window #(
        .PROM_BYTES (PROM_BYTES),
        .PMEM_LO    (PMEM_LO),
        .PMEM_HI    (PMEM_HI)
    ) u_win (
        .addr     (cur_addr),
        .wide     (wide),
        .eff_addr (eff_addr),
        .in_win   (in_win),
        .lane_be  (lane_be)
    );

    rdma_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .dp_rd     (dp_rd),
        .dp_wr     (dp_wr),
        .dp_wdata  (dp_wdata),
        .cnt_zero  (cur_cnt == '0),
        .wide      (wide),
        .eff_addr  (eff_addr),
        .in_win    (in_win),
        .lane_be   (lane_be),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .adv       (adv),
        .dp_rdata  (dp_rdata),
        .dp_rvalid (dp_rvalid)
    );

endmodule

// File: rtl/rdma_port_checker.sv
module rdma_port_checker #(
    parameter int PROM_BYTES = 32,
    parameter int PMEM_LO    = 16'h4000,
    parameter int PMEM_HI    = 16'h8000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [3:0]  reg_sel,
    input logic [7:0]  reg_wdata,
    input logic        dp_rd,
    input logic        dp_wr,
    input logic        dp_rvalid,
    input logic        mem_req,
    input logic [14:0] mem_addr,
    input logic [1:0]  mem_be,
    input logic        dma_done,
    input logic        adv,
    input logic        wide,
    input logic [1:0]  step,
    input logic [15:0] cur_addr,
    input logic [15:0] cur_cnt,
    input logic [15:0] ring_start,
    input logic [15:0] ring_stop
);

    logic [31:0] byte_addr;
    assign byte_addr = {16'd0, mem_addr, 1'b0};

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!dma_done && !dp_rvalid));

    // R3
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !reg_wr && cur_cnt > 16'(step)) |=> cur_cnt == $past(cur_cnt) - 16'($past(step)));

    // R4
    a_r4_ring_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !reg_wr && (cur_addr + 16'(step)) == ring_stop) |=> cur_addr == $past(ring_start));

    // R5
    a_r5_exhaust_done: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !reg_wr && cur_cnt <= 16'(step)) |=> (dma_done && cur_cnt == 16'd0));

    // R6
    a_r6_write_idle_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_wr && !dp_rd && cur_cnt == 16'd0) |-> !mem_req);

    // R7
    a_r7_empty_cmd_done: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 4'd0 && !reg_wdata[0] && (reg_wdata[3] || reg_wdata[4]) &&
         cur_cnt == 16'd0) |=> dma_done);

    // R8
    a_r8_rvalid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        dp_rd |=> dp_rvalid);
    a_r8_rvalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_rd |=> !dp_rvalid);

    // R9
    a_r9_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && wide) |-> mem_be == 2'b11);

    // R10
    a_r10_window_only: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((byte_addr < 32'(PROM_BYTES)) ||
                     (byte_addr >= 32'(PMEM_LO) && byte_addr < 32'(PMEM_HI))));

    // R11
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && !reg_wr) |=> dma_done);

endmodule

bind rdma_port_engine rdma_port_checker #(
    .PROM_BYTES (PROM_BYTES),
    .PMEM_LO    (PMEM_LO),
    .PMEM_HI    (PMEM_HI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .dp_rd      (dp_rd),
    .dp_wr      (dp_wr),
    .dp_rvalid  (dp_rvalid),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .dma_done   (dma_done),
    .adv        (adv),
    .wide       (wide),
    .step       (step),
    .cur_addr   (cur_addr),
    .cur_cnt    (cur_cnt),
    .ring_start (ring_start),
    .ring_stop  (ring_stop)
);

// File: tb/tb_rdma_port_engine.sv
module tb_rdma_port_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [3:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic        dp_rd, dp_wr;
    logic [15:0] dp_wdata;
    logic [15:0] dp_rdata;
    logic        dp_rvalid;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        dma_done;

    always #5 clk = ~clk;

    rdma_port_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
        .dp_rvalid(dp_rvalid), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dma_done(dma_done)
    );

    // bench-side RAM
    logic [15:0] ram [0:32767];
    always_ff @(posedge clk) begin
        if (mem_req && mem_we) begin
            if (mem_be[0]) ram[mem_addr][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) ram[mem_addr][15:8] <= mem_wdata[15:8];
        end
        if (mem_req && !mem_we) mem_rdata <= ram[mem_addr];
    end

    // reference model
    logic [7:0]  ref_mem [0:65535];
    logic [15:0] m_addr, m_cnt;
    logic [7:0]  m_first, m_end;
    logic        m_wide, m_done;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;

    function automatic logic [15:0] pat(input int i);
        return {8'(i) ^ 8'hA5, 8'(i >> 3) + 8'h3C};
    endfunction

    function automatic logic in_win(input logic [15:0] a);
        return (a < 16'd32) || (a >= 16'h4000 && a < 16'h8000);
    endfunction

    function automatic logic [15:0] eff(input logic [15:0] a);
        return m_wide ? {a[15:1], 1'b0} : a;
    endfunction

    function automatic logic [15:0] exp_read(input logic [15:0] a);
        if (!in_win(a)) return m_wide ? 16'hFFFF : 16'h00FF;
        if (m_wide) return {ref_mem[a + 16'd1], ref_mem[a]};
        return {8'h00, ref_mem[a]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic m_advance();
        logic [15:0] s;
        s = m_wide ? 16'd2 : 16'd1;
        m_addr = m_addr + s;
        if (m_addr == {m_end, 8'h00}) m_addr = {m_first, 8'h00};
        if (m_cnt <= s) begin m_cnt = 0; m_done = 1; end
        else m_cnt = m_cnt - s;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wreg(input logic [3:0] sel, input logic [7:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr = 0;
        case (sel)
            4'd0: if (!d[0] && (d[3] || d[4]) && m_cnt == 0) m_done = 1;
            4'd1: m_first = d;
            4'd2: m_end = d;
            4'd3: m_wide = d[0];
            4'd4: m_addr[7:0] = d;
            4'd5: m_addr[15:8] = d;
            4'd6: m_cnt[7:0] = d;
            4'd7: m_cnt[15:8] = d;
            4'd8: if (d[6]) m_done = 0;
            default: ;
        endcase
        chk("R2/R7/R11 done after reg write", {31'd0, dma_done}, {31'd0, m_done});
    endtask

    task automatic dwrite(input logic [15:0] w);
        logic [15:0] a;
        logic        accept;
        a = eff(m_addr);
        accept = (m_cnt != 0);
        dp_wr = 1; dp_wdata = w;
        #1;
        chk("R6/R10 mem_req on write", {31'd0, mem_req}, {31'd0, accept && in_win(a)});
        if (mem_req && m_wide) chk("R9 word lanes", {30'd0, mem_be}, 32'd3);
        if (mem_req && !m_wide) chk("R9 byte lane", {30'd0, mem_be}, a[0] ? 32'd2 : 32'd1);
        tick();
        dp_wr = 0;
        if (accept) begin
            if (in_win(a)) begin
                ref_mem[a] = w[7:0];
                if (m_wide) ref_mem[a + 16'd1] = w[15:8];
            end
            m_advance();
        end
        chk("R3/R5/R6 done after write", {31'd0, dma_done}, {31'd0, m_done});
    endtask

    task automatic dread();
        logic [15:0] e;
        e = exp_read(eff(m_addr));
        dp_rd = 1;
        tick();
        dp_rd = 0;
        chk("R8 rvalid", {31'd0, dp_rvalid}, 32'd1);
        chk("R8/R9/R10 read data", {16'd0, dp_rdata}, {16'd0, e});
        m_advance();
        chk("R3/R5 done after read", {31'd0, dma_done}, {31'd0, m_done});
    endtask

    task automatic set_ptr(input logic [15:0] a, input logic [15:0] c);
        wreg(4'd4, a[7:0]); wreg(4'd5, a[15:8]);
        wreg(4'd6, c[7:0]); wreg(4'd7, c[15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] a0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 32768; i++) begin
            ram[i] = pat(i);
            ref_mem[2*i]   = pat(i)[7:0];
            ref_mem[2*i+1] = pat(i)[15:8];
        end
        rst_n = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        dp_rd = 0; dp_wr = 0; dp_wdata = 0;
        m_addr = 0; m_cnt = 0; m_first = 0; m_end = 0; m_wide = 0; m_done = 0;
        repeat (3) @(negedge clk);
        chk("R1 done at reset", {31'd0, dma_done}, 32'd0);
        chk("R1 rvalid at reset", {31'd0, dp_rvalid}, 32'd0);
        rst_n = 1;
        tick();

        // R6: write with zero count is ignored
        wreg(4'd4, 8'h10); wreg(4'd5, 8'h40);
        dwrite(16'h00AB);
        dread();  // count 0 read still performs and sets done (R5)
        chk("R6 pointer held (read at 0x4010)", {16'd0, m_addr}, 32'h4011);

        // R11 clear with/without bit6
        wreg(4'd8, 8'h00);
        chk("R11 clear w/o bit6 keeps done", {31'd0, dma_done}, 32'd1);
        wreg(4'd8, 8'h40);
        chk("R11 clear bit6", {31'd0, dma_done}, 32'd0);

        // R7 empty-transfer commands
        wreg(4'd0, 8'h09);
        chk("R7 halt set no done", {31'd0, dma_done}, 32'd0);
        wreg(4'd0, 8'h12);
        chk("R7 remote write empty cmd", {31'd0, dma_done}, 32'd1);
        wreg(4'd8, 8'h40);
        wreg(4'd6, 8'h05);
        wreg(4'd0, 8'h0A);
        chk("R7 nonzero count no done", {31'd0, dma_done}, 32'd0);

        // R2 half preservation: change only low byte of pointer
        wreg(4'd4, 8'h20); wreg(4'd5, 8'h41);
        wreg(4'd4, 8'h22);
        dwrite(16'h005A);
        wreg(4'd4, 8'h22);
        wreg(4'd6, 8'h01);
        dread();

        // R4 byte-mode wrap
        wreg(4'd1, 8'h40); wreg(4'd2, 8'h42);
        set_ptr(16'h41FF, 16'd3);
        dwrite(16'h0011); dwrite(16'h0022); dwrite(16'h0033);
        chk("R4 wrap to first", {16'd0, m_addr}, 32'h4002);
        set_ptr(16'h41FF, 16'd3);
        dread(); dread(); dread();

        // R9 word mode, odd pointer forced even, wrap
        wreg(4'd3, 8'h01);
        wreg(4'd8, 8'h40);
        set_ptr(16'h41FD, 16'd4);
        dwrite(16'hBEEF); dwrite(16'hCAFE);
        set_ptr(16'h41FC, 16'd5);
        dread(); dread(); dread();

        // R10 out-of-window in both widths
        set_ptr(16'h2000, 16'd2);
        dwrite(16'h1234); dread();
        wreg(4'd3, 8'h00);
        set_ptr(16'h001F, 16'd2);
        dread(); dread();

        // R8 read priority over write
        set_ptr(16'h4100, 16'd4);
        dp_wr = 1;
        dread();
        dp_wr = 0;

        // constrained random
        for (int k = 0; k < 3000; k++) begin
            int op;
            op = int'($urandom_range(0, 9));
            case (op)
                0: begin
                    a0 = 16'h4000 + 16'($urandom_range(0, 16'h3FFF));
                    case ($urandom_range(0, 3))
                        0: a0 = 16'($urandom_range(0, 40));
                        1: a0 = 16'($urandom_range(0, 16'hFFFF));
                        default: ;
                    endcase
                    set_ptr(a0, 16'($urandom_range(0, 12)));
                end
                1: begin
                    wreg(4'd1, 8'($urandom_range(8'h40, 8'h7E)));
                    wreg(4'd2, 8'($urandom_range(int'(m_first) + 1, 8'h80)));
                end
                2: wreg(4'd3, 8'($urandom_range(0, 1)));
                3: wreg(4'd0, 8'($urandom_range(0, 255)));
                4: wreg(4'd8, 8'($urandom_range(0, 255)));
                5, 6: dwrite(16'($urandom_range(0, 16'hFFFF)));
                default: dread();
            endcase
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule